// File: doc/BRIEF.md
# Set-Associative Instruction TLB

This block turns an instruction-fetch virtual address into a physical address. It keeps a set-associative table of page mappings with a configurable number of sets and one to four ways. Each entry is held as two software-visible words. The match word holds a virtual page tag, a valid bit and a per-entry recency counter. The translate word holds a physical page number and a cache-inhibit bit. A lookup is launched by a fetch strobe. One cycle later the block returns a registered result: hit or miss, the physical address, a cache-inhibit flag, and, on a miss, a miss-exception request that carries the faulting address. The block does no refill. A miss only raises the exception, and software then loads the entry through the register port.

When translation is switched off, or the unit is reported as absent, the block passes the address straight through. In that case cache inhibit follows the top address bit. On every hit the recency counters of the addressed set age by one, and the hit entry is reloaded with the largest count.

Top module: `itlb_top`

## Requirements
- R1: When `xlat_en` is low or `xlat_present` is low, a fetch returns `rsp_pa` equal to the fetch address and `rsp_ci` equal to its top bit (address at or above 0x80000000). Both `rsp_hit` and `rsp_miss` stay low.
- R2: The set is fetch-address bits [PAGE_BITS +: SET_BITS], which is (address / page size) mod sets. The page number compared is bits [ADDR_W-1 : PAGE_BITS+SET_BITS].
- R3: A way hits only when its entry in the selected set is valid and its tag equals the page number. When several ways hit, the highest-numbered one is used. Hit and miss are never both high.
- R4: On a hit, each other way in the selected set with a nonzero counter decrements it by one. The hit way's counter is loaded with sets − 1.
- R5: Register port address is {kind[1:0], way[1:0], set[SET_BITS-1:0]}, with kind 0 = match word, 1 = translate word, 2 = configuration. Match word: valid at bit 0, counter at bits [6 +: SET_BITS], tag at bits [ADDR_W-1 : PAGE_BITS+SET_BITS]. Translate word: cache inhibit at bit 1, page number at bits [ADDR_W-1:12]. Bits that are not stored read back as 0.
- R6: On a hit, `rsp_ci` is the cache-inhibit bit of the hit way's translate word.
- R7: On a hit, `rsp_pa` is page number × page size plus (fetch address mod page size), truncated to ADDR_W bits.
- R8: On a miss with translation active, `rsp_miss` and `exc_req` are high, `exc_va` is the fetch address and `rsp_pa` is 0.
- R9: The configuration word reads (ways − 1) in bits [1:0] and log2(sets) in bits [6:3]. All other bits read 0.
- R10: The results appear on the edge after the fetch strobe, with `rsp_valid` high for exactly that one cycle. Without a strobe, `rsp_valid`, `rsp_hit`, `rsp_miss` and `exc_req` are low.
- R11: A register write takes effect for the next lookup. When a match-word write and a hit's counter update hit the same entry in the same cycle, the written value wins, while the other ways in the set still age.
- R12: After reset, every valid bit and counter reads 0 and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Translation enable |
| xlat_present | input | 1 | Unit reported as implemented |
| fetch_valid | input | 1 | Lookup strobe |
| fetch_va | input | ADDR_W | Fetch virtual address |
| rsp_valid | output | 1 | Result valid, one cycle after strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_pa | output | ADDR_W | Physical address |
| rsp_ci | output | 1 | Cache inhibit |
| exc_req | output | 1 | Instruction TLB miss exception request |
| exc_va | output | ADDR_W | Faulting virtual address |
| reg_addr | input | 4+SET_BITS | Register port entry select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data, one cycle after address |

## Verification
The bench loads two ways of one set with the same tag. A design that picks the lowest way, or ORs the ways together, returns the wrong page and inhibit flag. It also writes a matching tag with the valid bit clear, which a careless compare would report as a hit. The counters are read back after runs of hits, so a counter that wraps below zero, forgets to age the other ways, or reloads with the wrong value shows up as a wrong readback. A same-cycle write and hit on one entry checks that the software value survives the update. The pass-through path is driven just below and at 0x80000000, which catches an off-by-one inhibit threshold or a lookup that still fires while translation is off.

// File: rtl/itlb_pkg.sv
// Package: shared constants and types for the instruction TLB.
// Assumes a register word of at least 16 bits; field positions are fixed
// because software decodes them.
package itlb_pkg;

    typedef enum logic [1:0] {
        KIND_MATCH = 2'd0,
        KIND_XLAT  = 2'd1,
        KIND_CFG   = 2'd2,
        KIND_NONE  = 2'd3
    } reg_kind_e;

    localparam int MW_VALID_BIT = 0;   // valid flag in match word
    localparam int MW_CNT_LSB   = 6;   // recency counter lsb in match word
    localparam int TW_CI_BIT    = 1;   // cache inhibit in translate word
    localparam int TW_PPN_LSB   = 12;  // page number lsb in translate word
    localparam int CFG_SETS_LSB = 3;   // log2(sets) lsb in config word

endpackage

// File: rtl/itlb_way.sv
// Module: one way of the TLB, storing valid, tag, counter, page number and
// cache inhibit for every set. Provides a lookup read port, a software read
// port and the per-hit counter update. A software match-word write to an
// entry overrides the counter update to that entry in the same cycle.
// Assumes SET_BITS >= 1.
module itlb_way #(
    parameter int SET_BITS = 4,
    parameter int VPN_W    = 15,
    parameter int PPN_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] lk_set,
    output logic                lk_valid,
    output logic [VPN_W-1:0]    lk_tag,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic                lk_ci,
    input  logic [SET_BITS-1:0] rd_set,
    output logic                rd_valid,
    output logic [VPN_W-1:0]    rd_tag,
    output logic [SET_BITS-1:0] rd_cnt,
    output logic [PPN_W-1:0]    rd_ppn,
    output logic                rd_ci,
    input  logic                upd_en,
    input  logic                upd_mru,
    input  logic                wr_match,
    input  logic                wr_xlat,
    input  logic [SET_BITS-1:0] wr_set,
    input  logic                wr_valid,
    input  logic [SET_BITS-1:0] wr_cnt,
    input  logic [VPN_W-1:0]    wr_tag,
    input  logic [PPN_W-1:0]    wr_ppn,
    input  logic                wr_ci
);
    localparam int SETS = 1 << SET_BITS;
    localparam logic [SET_BITS-1:0] CNT_TOP = SET_BITS'(SETS - 1);

    logic [SETS-1:0]     valid_q;
    logic [SETS-1:0]     ci_q;
    logic [VPN_W-1:0]    tag_q [SETS];
    logic [PPN_W-1:0]    ppn_q [SETS];
    logic [SET_BITS-1:0] cnt_q [SETS];

    // Lookup and software read ports.
    always_comb begin
        lk_valid = valid_q[lk_set];
        lk_tag   = tag_q[lk_set];
        lk_ppn   = ppn_q[lk_set];
        lk_ci    = ci_q[lk_set];
        rd_valid = valid_q[rd_set];
        rd_tag   = tag_q[rd_set];
        rd_cnt   = cnt_q[rd_set];
        rd_ppn   = ppn_q[rd_set];
        rd_ci    = ci_q[rd_set];
    end

    // Entry storage: software writes first, otherwise counter aging on hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ci_q    <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                ppn_q[s] <= '0;
                cnt_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (wr_match && wr_set == SET_BITS'(s)) begin
                    valid_q[s] <= wr_valid;
                    tag_q[s]   <= wr_tag;
                    cnt_q[s]   <= wr_cnt;
                end else if (upd_en && lk_set == SET_BITS'(s)) begin
                    if (upd_mru)
                        cnt_q[s] <= CNT_TOP;
                    else if (cnt_q[s] != '0)
                        cnt_q[s] <= cnt_q[s] - 1'b1;
                end
                if (wr_xlat && wr_set == SET_BITS'(s)) begin
                    ppn_q[s] <= wr_ppn;
                    ci_q[s]  <= wr_ci;
                end
            end
        end
    end

    // Checker state: remembers an uncontested most-recent load.
    logic                a_mru_q;
    logic [SET_BITS-1:0] a_set_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_mru_q <= 1'b0;
            a_set_q <= '0;
        end else begin
            a_mru_q <= upd_en && upd_mru && !(wr_match && wr_set == lk_set);
            a_set_q <= lk_set;
        end
    end

    // R4: the hit entry holds the top count after its update.
    p_mru_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_mru_q |-> cnt_q[a_set_q] == CNT_TOP);

    // R11: a software match write lands exactly as written.
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> valid_q[$past(wr_set)] == $past(wr_valid));

endmodule

// File: rtl/itlb_hit_sel.sv
// Module: picks the highest-numbered way among the matching ways.
// Assumes WAYS between 1 and 4; idx is meaningless when any is low.
module itlb_hit_sel #(
    parameter int WAYS   = 4,
    parameter int IDX_W  = 2
) (
    input  logic [WAYS-1:0]  match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Priority scan, later ways overriding earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                any = 1'b1;
                idx = IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/itlb_top.sv
// Module: set-associative instruction TLB with one-cycle registered lookup,
// software register port and pass-through when translation is off.
// Assumes 1 <= WAYS <= 4, 1 <= SET_BITS <= 8, PAGE_BITS >= 12 and
// ADDR_W > PAGE_BITS + SET_BITS.
module itlb_top
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 4,
    parameter int WAYS      = 4,
    localparam int REG_AW   = 4 + SET_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              xlat_present,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_ci,
    output logic              exc_req,
    output logic [ADDR_W-1:0] exc_va,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata
);
    localparam int VPN_LSB = PAGE_BITS + SET_BITS;
    localparam int VPN_W   = ADDR_W - VPN_LSB;
    localparam int PPN_W   = ADDR_W - TW_PPN_LSB;
    localparam int IDX_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 1);

    // Lookup decode.
    logic                active;
    logic [SET_BITS-1:0] lk_set;
    logic [VPN_W-1:0]    lk_vpn;
    assign active = xlat_en && xlat_present;
    assign lk_set = fetch_va[PAGE_BITS +: SET_BITS];
    assign lk_vpn = fetch_va[ADDR_W-1 : VPN_LSB];

    // Register port decode.
    reg_kind_e           reg_kind;
    logic [1:0]          reg_way;
    logic [SET_BITS-1:0] reg_set;
    assign reg_kind = reg_kind_e'(reg_addr[REG_AW-1 -: 2]);
    assign reg_way  = reg_addr[SET_BITS +: 2];
    assign reg_set  = reg_addr[SET_BITS-1:0];

    logic [WAYS-1:0]     lk_valid, lk_ci, way_match, rd_valid, rd_ci;
    logic [WAYS-1:0]     wr_match, wr_xlat;
    logic [VPN_W-1:0]    lk_tag [WAYS];
    logic [PPN_W-1:0]    lk_ppn [WAYS];
    logic [VPN_W-1:0]    rd_tag [WAYS];
    logic [SET_BITS-1:0] rd_cnt [WAYS];
    logic [PPN_W-1:0]    rd_ppn [WAYS];
    logic                any_hit, upd_en;
    logic [IDX_W-1:0]    hit_way;

    assign upd_en = fetch_valid && active && any_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per-way write strobes and tag comparison.
        assign wr_match[w]  = reg_we && reg_kind == KIND_MATCH && reg_way == 2'(w);
        assign wr_xlat[w]   = reg_we && reg_kind == KIND_XLAT  && reg_way == 2'(w);
        assign way_match[w] = lk_valid[w] && lk_tag[w] == lk_vpn;

        itlb_way #(
            .SET_BITS(SET_BITS),
            .VPN_W   (VPN_W),
            .PPN_W   (PPN_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_set   (lk_set),
            .lk_valid (lk_valid[w]),
            .lk_tag   (lk_tag[w]),
            .lk_ppn   (lk_ppn[w]),
            .lk_ci    (lk_ci[w]),
            .rd_set   (reg_set),
            .rd_valid (rd_valid[w]),
            .rd_tag   (rd_tag[w]),
            .rd_cnt   (rd_cnt[w]),
            .rd_ppn   (rd_ppn[w]),
            .rd_ci    (rd_ci[w]),
            .upd_en   (upd_en),
            .upd_mru  (hit_way == IDX_W'(w)),
            .wr_match (wr_match[w]),
            .wr_xlat  (wr_xlat[w]),
            .wr_set   (reg_set),
            .wr_valid (reg_wdata[MW_VALID_BIT]),
            .wr_cnt   (reg_wdata[MW_CNT_LSB +: SET_BITS]),
            .wr_tag   (reg_wdata[ADDR_W-1 : VPN_LSB]),
            .wr_ppn   (reg_wdata[ADDR_W-1 : TW_PPN_LSB]),
            .wr_ci    (reg_wdata[TW_CI_BIT])
        );
    end

    itlb_hit_sel #(
        .WAYS (WAYS),
        .IDX_W(IDX_W)
    ) u_sel (
        .match(way_match),
        .any  (any_hit),
        .idx  (hit_way)
    );

    // Physical address of a hit: page number scaled by page size plus offset.
    logic [ADDR_W-1:0] hit_pa;
    assign hit_pa = ADDR_W'({lk_ppn[hit_way], {PAGE_BITS{1'b0}}}) | (fetch_va & OFS_MASK);

    // Lookup response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_pa    <= '0;
            rsp_ci    <= 1'b0;
            exc_req   <= 1'b0;
            exc_va    <= '0;
        end else begin
            rsp_valid <= fetch_valid;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            exc_req   <= 1'b0;
            if (fetch_valid) begin
                exc_va <= fetch_va;
                if (!active) begin
                    rsp_pa <= fetch_va;
                    rsp_ci <= fetch_va[ADDR_W-1];
                end else if (any_hit) begin
                    rsp_hit <= 1'b1;
                    rsp_pa  <= hit_pa;
                    rsp_ci  <= lk_ci[hit_way];
                end else begin
                    rsp_miss <= 1'b1;
                    exc_req  <= 1'b1;
                    rsp_pa   <= '0;
                    rsp_ci   <= 1'b0;
                end
            end
        end
    end

    // Register read word assembly.
    logic [ADDR_W-1:0] rd_word;
    always_comb begin
        rd_word = '0;
        if (32'(reg_way) < WAYS) begin
            case (reg_kind)
                KIND_MATCH: begin
                    rd_word[ADDR_W-1 : VPN_LSB]         = rd_tag[reg_way[IDX_W-1:0]];
                    rd_word[MW_CNT_LSB +: SET_BITS]     = rd_cnt[reg_way[IDX_W-1:0]];
                    rd_word[MW_VALID_BIT]               = rd_valid[reg_way[IDX_W-1:0]];
                end
                KIND_XLAT: begin
                    rd_word[ADDR_W-1 : TW_PPN_LSB] = rd_ppn[reg_way[IDX_W-1:0]];
                    rd_word[TW_CI_BIT]             = rd_ci[reg_way[IDX_W-1:0]];
                end
                default: ;
            endcase
        end
        if (reg_kind == KIND_CFG) begin
            rd_word[1:0]              = 2'(WAYS - 1);
            rd_word[CFG_SETS_LSB +: 4] = 4'(SET_BITS);
        end
    end

    // Register read data stage.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_word;
    end

    // R1: pass-through returns the fetch address.
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !active |=> rsp_pa == $past(fetch_va) && !rsp_hit && !rsp_miss);

    // R3: the selected way matches and no higher way does.
    p_highest_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (way_match >> hit_way) == WAYS'(1));

    // R3: hit and miss are exclusive.
    p_hit_miss_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));

    // R8: a miss carries a zero address and an exception request.
    p_miss_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> rsp_pa == '0 && exc_req && exc_va == $past(fetch_va));

    // R10: one response cycle per strobe.
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> rsp_valid);
    p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !exc_req);

endmodule

// File: tb/itlb_top_test.sv
module itlb_top_test;
    localparam int AW = 32, PB = 13, SB = 4, NW = 4, NS = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic xlat_en = 1'b0, xlat_present = 1'b1, fetch_valid = 1'b0, reg_we = 1'b0;
    logic [AW-1:0] fetch_va = '0, reg_wdata = '0;
    logic [SB+3:0] reg_addr = '0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_ci, exc_req;
    logic [AW-1:0] rsp_pa, exc_va, reg_rdata;

    itlb_top #(.ADDR_W(AW), .PAGE_BITS(PB), .SET_BITS(SB), .WAYS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .xlat_present(xlat_present),
        .fetch_valid(fetch_valid), .fetch_va(fetch_va), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .rsp_ci(rsp_ci),
        .exc_req(exc_req), .exc_va(exc_va), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit m_v [NW][NS];
    bit m_ci [NW][NS];
    logic [14:0] m_tag [NW][NS];
    logic [19:0] m_ppn [NW][NS];
    logic [3:0]  m_cnt [NW][NS];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Expected match word as defined by R5.
    function automatic logic [31:0] mword(input int w, input int s);
        return {m_tag[w][s], 17'b0} | (32'(m_cnt[w][s]) << 6) | 32'(m_v[w][s]);
    endfunction

    // Apply a software write to the model (R5 field positions).
    function automatic void model_write(input int kind, input int w, input int s, input logic [31:0] d);
        if (kind == 0) begin
            m_v[w][s] = d[0]; m_cnt[w][s] = d[9:6]; m_tag[w][s] = d[31:17];
        end else if (kind == 1) begin
            m_ppn[w][s] = d[31:12]; m_ci[w][s] = d[1];
        end
    endfunction

    // One cycle: optional lookup and optional write, checked one edge later.
    task automatic step(input bit fv, input logic [31:0] va, input bit en, input bit pres,
                        input bit we, input int kind, input int w, input int s, input logic [31:0] d);
        int set, hw;
        logic [31:0] epa;
        bit ehit, emiss, eci;
        fetch_valid = fv; fetch_va = va; xlat_en = en; xlat_present = pres;
        reg_we = we; reg_addr = {2'(kind), 2'(w), 4'(s)}; reg_wdata = d;
        set = int'(va[16:13]); hw = -1;
        for (int i = 0; i < NW; i++) if (m_v[i][set] && m_tag[i][set] == va[31:17]) hw = i;
        ehit = 0; emiss = 0; eci = 0; epa = 0;
        if (!(en && pres)) begin epa = va; eci = va[31]; end
        else if (hw >= 0) begin ehit = 1; epa = {m_ppn[hw][set][18:0], va[12:0]}; eci = m_ci[hw][set]; end
        else emiss = 1;
        @(negedge clk);
        fetch_valid = 0; reg_we = 0;
        check(rsp_valid == fv, "R10 rsp_valid", 32'(rsp_valid), 32'(fv));
        if (fv) begin
            check(rsp_hit == ehit, "R3 hit", 32'(rsp_hit), 32'(ehit));
            check(rsp_miss == emiss && exc_req == emiss, "R8 miss/exc", 32'({rsp_miss, exc_req}), 32'({emiss, emiss}));
            check(rsp_pa == epa, ehit ? "R7 hit pa" : (emiss ? "R8 miss pa" : "R1 pass pa"), rsp_pa, epa);
            check(rsp_ci == eci, ehit ? "R6 ci" : "R1 ci", 32'(rsp_ci), 32'(eci));
            if (emiss) check(exc_va == va, "R8 exc_va", exc_va, va);
            if (ehit)
                for (int i = 0; i < NW; i++)
                    if (i == hw) m_cnt[i][set] = 4'(NS - 1);
                    else if (m_cnt[i][set] != 0) m_cnt[i][set] = m_cnt[i][set] - 1;
        end else begin
            check(!rsp_hit && !rsp_miss && !exc_req, "R10 idle", 32'({rsp_hit, rsp_miss, exc_req}), 0);
        end
        if (we) model_write(kind, w, s, d);
    endtask

    task automatic wr(input int kind, input int w, input int s, input logic [31:0] d);
        step(0, 0, 1, 1, 1, kind, w, s, d);
    endtask

    task automatic rd(input int kind, input int w, input int s, output logic [31:0] q);
        reg_addr = {2'(kind), 2'(w), 4'(s)};
        @(negedge clk);
        q = reg_rdata;
    endtask

    task automatic check_set_cnt(input int s, input string req);
        logic [31:0] q;
        for (int w = 0; w < NW; w++) begin
            rd(0, w, s, q);
            check(q == mword(w, s), req, q, mword(w, s));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] q, va;
        void'($urandom(32'h1c05));
        for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin
            m_v[w][s] = 0; m_ci[w][s] = 0; m_tag[w][s] = 0; m_ppn[w][s] = 0; m_cnt[w][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: state and outputs after reset.
        check(!rsp_valid && !rsp_hit && !rsp_miss && !exc_req, "R12 outputs", 32'({rsp_valid, rsp_hit, rsp_miss, exc_req}), 0);
        for (int s = 0; s < NS; s += 5) begin
            rd(0, 3, s, q);
            check(q == 0, "R12 entry cleared", q, 0);
        end
        // R9: configuration word.
        rd(2, 0, 0, q);
        check(q == 32'h23, "R9 config", q, 32'h23);
        // R1: pass-through around the inhibit threshold.
        step(1, 32'h7fff_ffff, 0, 1, 0, 0, 0, 0, 0);
        step(1, 32'h8000_0000, 0, 1, 0, 0, 0, 0, 0);
        step(1, 32'h1234_5678, 1, 0, 0, 0, 0, 0, 0);
        // R8: empty table misses.
        step(1, 32'h0040_2000, 1, 1, 0, 0, 0, 0, 0);
        // Fill the table; stray bits in non-stored positions (R5).
        for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin
            wr(0, w, s, ($urandom() & 32'hffff_fc3e) | 32'(($urandom() % 4) != 0));
            wr(1, w, s, $urandom());
        end
        for (int s = 0; s < NS; s += 3) check_set_cnt(s, "R5 match readback");
        rd(1, 2, 7, q);
        check(q == ({m_ppn[2][7], 12'b0} | 32'(m_ci[2][7]) << 1), "R5 translate readback", q, {m_ppn[2][7], 12'b0} | 32'(m_ci[2][7]) << 1);
        // R3: ways 1 and 3 of set 5 share a tag; highest wins.
        wr(0, 1, 5, 32'h5556_0001);
        wr(0, 3, 5, 32'h5556_0041);
        wr(1, 1, 5, 32'h0001_1000);
        wr(1, 3, 5, 32'h0002_2002);
        step(1, 32'h5556_a123, 1, 1, 0, 0, 0, 0, 0);
        check_set_cnt(5, "R4 count after hit");
        // R3: matching tag with valid clear misses.
        wr(0, 0, 9, 32'h7770_0000);
        for (int w = 1; w < NW; w++) wr(0, w, 9, 32'h1110_0001);
        step(1, 32'h7771_2000, 1, 1, 0, 0, 0, 0, 0);
        // R2/R7: random lookups, mostly toward stored entries.
        for (int n = 0; n < 600; n++) begin
            int w, s;
            w = int'($urandom() % NW); s = int'($urandom() % NS);
            if (($urandom() % 4) != 0) va = {m_tag[w][s], 4'(s), 13'($urandom())};
            else va = $urandom();
            step(1, va, ($urandom() % 16) != 0, 1, 0, 0, 0, 0, 0);
            if (n % 50 == 0) check_set_cnt(s, "R4 count readback");
        end
        // R4: repeated hits age others down to zero without wrap.
        wr(0, 0, 2, 32'h2220_0001 | (32'd2 << 6));
        wr(0, 1, 2, 32'h3330_0001 | (32'd15 << 6));
        for (int n = 0; n < 4; n++) step(1, 32'h3330_4000, 1, 1, 0, 0, 0, 0, 0);
        check_set_cnt(2, "R4 saturate at zero");
        // R11: write and hit to the same entry in one cycle.
        step(1, 32'h3330_4000, 1, 1, 1, 0, 1, 2, 32'h3330_0001 | (32'd3 << 6));
        check_set_cnt(2, "R11 write priority");
        // R11: write takes effect for the next lookup.
        wr(0, 1, 2, 32'h4440_0001);
        step(1, 32'h4440_4abc, 1, 1, 0, 0, 0, 0, 0);
        step(1, 32'h3330_4000, 1, 1, 0, 0, 0, 0, 0);
        finish_up();
    end
endmodule